// File: doc/BRIEF.md
# Multi-Waveform Numerically Controlled Oscillator

This block produces one unsigned 8-bit sample per clock for an external DAC. All four waveforms come from a single 32-bit phase accumulator: sawtooth, sine, square and triangle. The accumulator adds a frequency tuning word on every clock of the 50 MHz system clock, so the output frequency is tuning word × 50 MHz / 2^32. A tuning word near 257,698 therefore gives about 3 kHz.

A 2-bit selector picks the waveform that reaches the output register. The waveforms share the phase, so changing the selector or the tuning word never restarts the waveform. The sine uses a quarter-wave table of 64 magnitudes. The two top phase bits select the quadrant. In odd quadrants the table address is mirrored, and in the second half of the period the magnitude is subtracted from midscale instead of added. The square wave's high fraction is set by an 8-bit duty input.

Top module: `wavegen_nco`

## Requirements
- R1: While the synchronous active-high reset is asserted, the sample is 128 (midscale) and the phase is cleared to 0. The first sample after release is therefore the selected waveform evaluated at phase 0.
- R2: The phase adds the tuning word on every clock that is not in reset, and wraps modulo 2^32.
- R3: Selector 00 gives a sawtooth: the sample equals phase bits [31:24].
- R4: Selector 01 gives a sine. Let b be phase bits [31:24]. The sample lies within one LSB of 128 + 127·sin(2π(b+0.5)/256) and is never 0. For b in 0x40..0x7F the value is the same as for b in 0x00..0x3F mirrored about the quarter point.
- R5: In sine mode, the samples at phases p and p + 2^31 sum to 256.
- R6: Selector 10 gives a square wave. The sample is 0xFF when phase bits [31:24] are at or above 256 − duty, and 0x00 otherwise. A duty of 128 gives 50 percent high, and a duty of 0 never goes high.
- R7: Selector 11 gives a triangle. Let t be phase bits [31:23]. The sample is t[7:0] when t[8] is 0, and the bitwise inverse of t[7:0] when t[8] is 1.
- R8: The output is registered. The sample after a clock edge is formed from the phase, selector and duty in effect just before that edge.
- R9: A change of selector, tuning word or duty takes effect on the next clock without resetting the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Waveform select: 00 sawtooth, 01 sine, 10 square, 11 triangle |
| ftw | input | 32 | Frequency tuning word added to the phase each clock |
| duty | input | 8 | Square-wave high fraction in 1/256 steps |
| sample | output | 8 | Registered unsigned output sample |

## Verification
Two events can fall in the same clock: a selector or tuning-word change, and the ongoing phase advance. The bench changes mode, tuning word and duty every 50 clocks while the accumulator keeps running. On each of these clocks it checks the sample against a model that uses the phase before the edge together with the newly applied settings, so both a lost phase and a one-cycle mode lag would be reported. A second coincidence is the accumulator wrap past 2^32 in the same cycle as a sample. A table entry with a wrapping step checks that the sample lands back at zero.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

    localparam int PHASE_W  = 32;
    localparam int SAMPLE_W = 8;
    localparam int LUT_AW   = 6;
    localparam int MAG_W    = 7;

    typedef enum logic [1:0] {
        WAVE_SAW    = 2'b00,
        WAVE_SINE   = 2'b01,
        WAVE_SQUARE = 2'b10,
        WAVE_TRI    = 2'b11
    } wave_e;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [MAG_W-1:0]    mag_t;
    typedef logic [LUT_AW-1:0]   lut_addr_t;

    typedef struct packed {
        logic [1:0] quad;
        lut_addr_t  addr;
    } sine_idx_t;

    localparam sample_t MIDSCALE = sample_t'(1 << (SAMPLE_W - 1));

    // Quarter-wave magnitudes: round(127*sin(pi/2*(a+0.5)/64))
    function automatic mag_t quarter_mag(input lut_addr_t a);
        mag_t m;
        case (a)
            6'd0:  m = 7'd2;   6'd1:  m = 7'd5;   6'd2:  m = 7'd8;   6'd3:  m = 7'd11;
            6'd4:  m = 7'd14;  6'd5:  m = 7'd17;  6'd6:  m = 7'd20;  6'd7:  m = 7'd23;
            6'd8:  m = 7'd26;  6'd9:  m = 7'd29;  6'd10: m = 7'd32;  6'd11: m = 7'd35;
            6'd12: m = 7'd38;  6'd13: m = 7'd41;  6'd14: m = 7'd44;  6'd15: m = 7'd47;
            6'd16: m = 7'd50;  6'd17: m = 7'd53;  6'd18: m = 7'd56;  6'd19: m = 7'd58;
            6'd20: m = 7'd61;  6'd21: m = 7'd64;  6'd22: m = 7'd67;  6'd23: m = 7'd69;
            6'd24: m = 7'd72;  6'd25: m = 7'd74;  6'd26: m = 7'd77;  6'd27: m = 7'd79;
            6'd28: m = 7'd82;  6'd29: m = 7'd84;  6'd30: m = 7'd86;  6'd31: m = 7'd89;
            6'd32: m = 7'd91;  6'd33: m = 7'd93;  6'd34: m = 7'd95;  6'd35: m = 7'd97;
            6'd36: m = 7'd99;  6'd37: m = 7'd101; 6'd38: m = 7'd103; 6'd39: m = 7'd105;
            6'd40: m = 7'd106; 6'd41: m = 7'd108; 6'd42: m = 7'd110; 6'd43: m = 7'd111;
            6'd44: m = 7'd113; 6'd45: m = 7'd114; 6'd46: m = 7'd115; 6'd47: m = 7'd117;
            6'd48: m = 7'd118; 6'd49: m = 7'd119; 6'd50: m = 7'd120; 6'd51: m = 7'd121;
            6'd52: m = 7'd122; 6'd53: m = 7'd123; 6'd54: m = 7'd124; 6'd55: m = 7'd124;
            6'd56: m = 7'd125; 6'd57: m = 7'd125; 6'd58: m = 7'd126; 6'd59: m = 7'd126;
            6'd60: m = 7'd127; 6'd61: m = 7'd127; 6'd62: m = 7'd127; default: m = 7'd127;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wg_phase_acc.sv
module wg_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase
);

    logic [PHASE_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + step;
    end

    assign phase = phase_q;

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase_q == $past(phase_q) + $past(step));

    // R1
    phase_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> phase_q == '0);

endmodule

// File: rtl/wg_sine_quarter.sv
module wg_sine_quarter
    import wavegen_pkg::*;
#(
    parameter int PHASE_W = 32
) (
    input  logic [PHASE_W-1:0] phase,
    output sample_t            y
);

    localparam int IDX_W = 2 + LUT_AW;

    sine_idx_t idx;
    lut_addr_t addr_eff;
    mag_t      mag;

    assign idx      = sine_idx_t'(phase[PHASE_W-1 -: IDX_W]);
    assign addr_eff = idx.quad[0] ? ~idx.addr : idx.addr;
    assign mag      = quarter_mag(addr_eff);

    always_comb begin
        if (idx.quad[1]) y = MIDSCALE - sample_t'(mag);
        else             y = MIDSCALE + sample_t'(mag);
    end

endmodule

// File: rtl/wg_shaper.sv
module wg_shaper
    import wavegen_pkg::*;
#(
    parameter int PHASE_W = 32
) (
    input  logic [PHASE_W-1:0]  phase,
    input  logic [1:0]          mode,
    input  logic [SAMPLE_W-1:0] duty,
    output sample_t             y
);

    localparam int TRI_W = SAMPLE_W + 1;

    sample_t           saw_y, sine_y, sq_y, tri_y;
    logic [TRI_W-1:0]  tri_t;
    logic [SAMPLE_W:0] sq_thresh;

    assign saw_y = phase[PHASE_W-1 -: SAMPLE_W];

    wg_sine_quarter #(.PHASE_W(PHASE_W)) u_sine (
        .phase (phase),
        .y     (sine_y)
    );

    assign sq_thresh = (SAMPLE_W+1)'(1 << SAMPLE_W) - {1'b0, duty};
    assign sq_y      = ({1'b0, saw_y} >= sq_thresh) ? '1 : '0;

    assign tri_t = phase[PHASE_W-1 -: TRI_W];
    assign tri_y = tri_t[SAMPLE_W] ? ~tri_t[SAMPLE_W-1:0] : tri_t[SAMPLE_W-1:0];

    always_comb begin
        unique case (wave_e'(mode))
            WAVE_SAW:    y = saw_y;
            WAVE_SINE:   y = sine_y;
            WAVE_SQUARE: y = sq_y;
            default:     y = tri_y;
        endcase
    end

endmodule

// File: rtl/wavegen_nco.sv
module wavegen_nco
    import wavegen_pkg::*;
#(
    parameter int PHASE_W = wavegen_pkg::PHASE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode,
    input  logic [PHASE_W-1:0]  ftw,
    input  logic [SAMPLE_W-1:0] duty,
    output logic [SAMPLE_W-1:0] sample
);

    logic [PHASE_W-1:0] phase;
    sample_t            next_y;
    sample_t            sample_q;

    wg_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .step  (ftw),
        .phase (phase)
    );

    wg_shaper #(.PHASE_W(PHASE_W)) u_shape (
        .phase (phase),
        .mode  (mode),
        .duty  (duty),
        .y     (next_y)
    );

    always_ff @(posedge clk) begin
        if (rst) sample_q <= MIDSCALE;
        else     sample_q <= next_y;
    end

    assign sample = sample_q;

    // R1
    reset_mid_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> sample_q == MIDSCALE);

    // R6
    square_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 2'b10) |-> (sample_q == '0 || sample_q == '1));

    // R4
    sine_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 2'b01) |-> sample_q != '0);

endmodule

// File: tb/wavegen_nco_test.sv
module wavegen_nco_test;

    localparam int CLK_PERIOD = 20;
    localparam real PI = 3.14159265358979;

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] ftw;
        logic [7:0]  duty;
        logic [7:0]  n;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 32'h0100_0000, 8'd128, 8'd6,  8'd5,   4'd3}, // R3 saw ramp
        '{2'b00, 32'h1000_0000, 8'd128, 8'd17, 8'd0,   4'd2}, // R2 wrap
        '{2'b01, 32'h4000_0000, 8'd128, 8'd1,  8'd130, 4'd4}, // R4 q0 addr0
        '{2'b01, 32'h4000_0000, 8'd128, 8'd2,  8'd255, 4'd4}, // R4 q1 mirrored peak
        '{2'b01, 32'h4000_0000, 8'd128, 8'd3,  8'd126, 4'd4}, // R4 q2
        '{2'b01, 32'h4000_0000, 8'd128, 8'd4,  8'd1,   4'd4}, // R4 q3 trough
        '{2'b10, 32'h4000_0000, 8'd128, 8'd3,  8'hFF,  4'd6}, // R6 at threshold
        '{2'b10, 32'h4000_0000, 8'd128, 8'd2,  8'h00,  4'd6}, // R6 below
        '{2'b10, 32'h4000_0000, 8'd0,   8'd4,  8'h00,  4'd6}, // R6 duty 0
        '{2'b10, 32'h0100_0000, 8'd255, 8'd2,  8'hFF,  4'd6}, // R6 duty 255
        '{2'b10, 32'h0100_0000, 8'd255, 8'd1,  8'h00,  4'd6}, // R6 duty 255 phase 0
        '{2'b11, 32'h0080_0000, 8'd128, 8'd3,  8'd2,   4'd7}, // R7 rising
        '{2'b11, 32'h8000_0000, 8'd128, 8'd2,  8'd255, 4'd7}, // R7 apex
        '{2'b11, 32'hC000_0000, 8'd128, 8'd2,  8'd127, 4'd7}  // R7 falling
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic [31:0] ftw = '0;
    logic [7:0]  duty = 8'd128;
    logic [7:0]  sample;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] ph_m = '0;
    int          sine_rec [256];

    wavegen_nco uut (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .ftw    (ftw),
        .duty   (duty),
        .sample (sample)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic real sine_ref(input logic [31:0] p);
        return 128.0 + 127.0 * $sin(2.0 * PI * (real'(p[31:24]) + 0.5) / 256.0);
    endfunction

    function automatic int exact_ref(input logic [31:0] p, input logic [1:0] m, input logic [7:0] d);
        int b = int'(p[31:24]);
        int t = int'(p[31:23]);
        case (m)
            2'b00:   return b;
            2'b10:   return (b >= 256 - int'(d)) ? 255 : 0;
            2'b11:   return (t >= 256) ? (255 - (t - 256)) : t;
            default: return -1;
        endcase
    endfunction

    task automatic judge(input string req, input logic [31:0] p, input logic [1:0] m, input logic [7:0] d);
        if (m == 2'b01) begin
            real r = sine_ref(p);
            real e = real'(int'(sample)) - r;
            check(req, (e <= 1.5) && (e >= -1.5) && sample != 0, int'(sample), int'(r + 0.5));
        end else begin
            int x = exact_ref(p, m, d);
            check(req, int'(sample) == x, int'(sample), x);
        end
    endtask

    // one clock; optionally check the new sample against the pre-edge state (R8)
    task automatic tick(input bit do_chk, input string req);
        logic [31:0] p = ph_m;
        logic [1:0]  m = mode;
        logic [7:0]  d = duty;
        @(posedge clk);
        ph_m = ph_m + ftw;
        @(negedge clk);
        if (do_chk) judge(req, p, m, d);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", sample == 8'd128, int'(sample), 128);
        ph_m = '0;
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: midscale held during reset
        do_reset();

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            mode = VECS[v].mode;
            ftw  = VECS[v].ftw;
            duty = VECS[v].duty;
            do_reset();
            for (int k = 0; k < int'(VECS[v].n); k++) tick(1'b0, "");
            check($sformatf("R%0d vec%0d", VECS[v].req, v),
                  sample == VECS[v].exp, int'(sample), int'(VECS[v].exp));
        end

        // R4 sine sweep across all 256 bins, R5 half-period antisymmetry
        mode = 2'b01;
        ftw  = 32'h0100_0000;
        do_reset();
        for (int k = 0; k < 256; k++) begin
            tick(1'b1, "R4");
            sine_rec[k] = int'(sample);
        end
        for (int b = 0; b < 128; b++)
            check("R5", sine_rec[b] + sine_rec[b + 128] == 256,
                  sine_rec[b] + sine_rec[b + 128], 256);
        for (int b = 0; b < 64; b++)
            check("R4 mirror", sine_rec[b] == sine_rec[127 - b], sine_rec[127 - b], sine_rec[b]);

        // R8/R9: settings change mid-run without phase restart
        do_reset();
        mode = 2'b00;
        ftw  = 32'h0123_4567;
        duty = 8'd64;
        for (int k = 0; k < 600; k++) begin
            if (k % 50 == 0 && k != 0) begin
                mode = mode + 2'd1;
                ftw  = (ftw == 32'h0123_4567) ? 32'h0765_4321 : 32'h0123_4567;
                duty = duty + 8'd37;
            end
            tick(1'b1, (k % 50 == 0) ? "R9" : "R8");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule